// File: doc/BRIEF.md
# Receive Interrupt Source Selector

This block sits beside the receive datapath of a buffered multichannel serial port. It holds the status flags that software polls: word ready, receiver full and frame-sync error. From one of four receive events, picked by a 2-bit mode field, it produces a single-cycle interrupt request. The word path is modelled only by its occupancy. A pulse loads a word into the buffer register. The word moves into the data register when that register is free. A read strobe frees the data register again.

The interrupt is edge-detected in every mode, so a source that stays high raises one pulse only. Holding the receiver in reset clears all three flags and blocks the request. The one exception is the frame-sync mode, which still reports pulses while the receiver is in reset. Bit shifting and channel selection take place upstream.

Top module: `rx_irq_select`

## Requirements
- R1: With mode 0, `irq` is high for one cycle in the same cycle that `rdy_flag` changes from 0 to 1. A word loaded by `buf_load` with the data register empty sets `rdy_flag` two clock edges after the load.
- R2: With mode 1, a rising edge on `blk_done` gives `irq` one edge later, but only while `mch_en` is 1. With `mch_en` at 0, mode 1 never raises `irq`.
- R3: With mode 2, a rising edge on `fsync_det` gives `irq` one edge later, even while `rx_reset` is 1.
- R4: With mode 3, `irq` is high for one cycle in the same cycle that `err_flag` changes from 0 to 1.
- R5: `err_flag` sets one edge after `fsync_unexp` and stays set. Only `err_wr0` or `rx_reset` clears it. When `fsync_unexp` and `err_wr0` arrive in the same cycle, the flag ends up set.
- R6: `full_flag` sets when the buffer holds a word, `shift_full` is 1 and `rdy_flag` is 1. It clears on `dreg_rd`. `full_flag` is never 1 while `rdy_flag` is 0.
- R7: `dreg_rd` clears `rdy_flag` on the next edge. If the buffer holds a word, that word moves into the data register one edge later and sets `rdy_flag` again.
- R8: While `rx_reset` is 1, all three flags read 0 after the next edge. In modes 0, 1 and 3, `irq` stays 0.
- R9: A source held high for several cycles yields exactly one `irq` cycle. `rst` clears every flag and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_mode | input | 2 | Interrupt source: 0 ready, 1 block, 2 frame sync, 3 sync error |
| mch_en | input | 1 | Multichannel selection mode active |
| rx_reset | input | 1 | Receiver held in reset (level) |
| buf_load | input | 1 | A received word enters the buffer register |
| shift_full | input | 1 | Shift register holds a complete new word |
| dreg_rd | input | 1 | Data register read strobe |
| blk_done | input | 1 | End of a 16-channel block |
| fsync_det | input | 1 | Receive frame-sync pulse detected |
| fsync_unexp | input | 1 | Unexpected frame-sync pulse |
| err_wr0 | input | 1 | Software writes 0 to the error flag |
| irq | output | 1 | Receive interrupt request pulse |
| rdy_flag | output | 1 | Data register holds an unread word |
| full_flag | output | 1 | Receiver-full condition |
| err_flag | output | 1 | Sticky frame-sync error |

## Verification
Suppose the buffer-occupancy bit is lost or stuck. The ready flag then fails to come back one edge after a read, or it comes back with no word queued, and mode 0 shows the wrong interrupt on that same edge. A wrong edge-detector register shows up within one or two cycles, as a second pulse or a missing pulse while a source is held high. A wrong reset gate shows up as an interrupt or a set flag on the first edge of receiver reset. The sweep covers every mode against both multichannel settings and both receiver-reset levels, so a misrouted mode bit is seen as a pulse under the wrong source.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        SRC_READY = 2'd0,
        SRC_BLOCK = 2'd1,
        SRC_FSYNC = 2'd2,
        SRC_FSERR = 2'd3
    } irq_src_e;

    typedef struct packed {
        logic rdy_rise;
        logic blk_rise;
        logic fs_rise;
        logic err_rise;
    } rx_evt_t;

    function automatic logic pick_event(irq_src_e src, rx_evt_t ev,
                                        logic mch, logic in_reset);
        logic hit;
        case (src)
            SRC_READY: hit = ev.rdy_rise & ~in_reset;
            SRC_BLOCK: hit = ev.blk_rise & mch & ~in_reset;
            SRC_FSYNC: hit = ev.fs_rise;
            default:   hit = ev.err_rise & ~in_reset;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/rx_word_flags.sv
module rx_word_flags (
    input  logic clk,
    input  logic rst,
    input  logic rx_reset,
    input  logic buf_load,
    input  logic shift_full,
    input  logic dreg_rd,
    output logic rdy,
    output logic full,
    output logic rdy_rise
);
    logic buf_v, buf_d, rdy_d, full_d, move;

    always_comb begin
        move   = buf_v & ~rdy;
        rdy_d  = rdy;
        buf_d  = buf_v;
        full_d = full | (buf_v & shift_full & rdy);
        if (dreg_rd) begin
            rdy_d  = 1'b0;
            full_d = 1'b0;
        end
        if (move) begin
            rdy_d = 1'b1;
            buf_d = 1'b0;
        end
        if (buf_load) buf_d = 1'b1;
        if (rx_reset) begin
            rdy_d  = 1'b0;
            buf_d  = 1'b0;
            full_d = 1'b0;
        end
    end

    assign rdy_rise = rdy_d & ~rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy   <= 1'b0;
            buf_v <= 1'b0;
            full  <= 1'b0;
        end else begin
            rdy   <= rdy_d;
            buf_v <= buf_d;
            full  <= full_d;
        end
    end

    // R6
    full_needs_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> rdy);

    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (dreg_rd && rdy) |=> !rdy && !full);

    // R8
    rx_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rx_reset |=> !rdy && !full);
endmodule

// File: rtl/rx_err_flag.sv
module rx_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic rx_reset,
    input  logic fsync_unexp,
    input  logic err_wr0,
    output logic err,
    output logic err_rise
);
    logic err_d;

    always_comb begin
        if (rx_reset) err_d = 1'b0;
        else          err_d = (err & ~err_wr0) | fsync_unexp;
    end

    assign err_rise = err_d & ~err;

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= err_d;
    end

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !err_wr0 && !rx_reset) |=> err);

    // R5
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        (fsync_unexp && !rx_reset) |=> err);
endmodule

// File: rtl/rx_irq_mux.sv
module rx_irq_mux
    import rx_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_src_e src,
    input  logic     mch_en,
    input  logic     rx_reset,
    input  logic     blk_done,
    input  logic     fsync_det,
    input  logic     rdy_rise,
    input  logic     err_rise,
    output logic     irq
);
    logic    blk_q, fs_q;
    rx_evt_t ev;

    always_comb begin
        ev.rdy_rise = rdy_rise;
        ev.blk_rise = blk_done & ~blk_q;
        ev.fs_rise  = fsync_det & ~fs_q;
        ev.err_rise = err_rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q <= 1'b0;
            fs_q  <= 1'b0;
            irq   <= 1'b0;
        end else begin
            blk_q <= blk_done;
            fs_q  <= fsync_det;
            irq   <= pick_event(src, ev, mch_en, rx_reset);
        end
    end

    // R8
    reset_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_reset && src != SRC_FSYNC) |=> !irq);

    // R2
    block_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_BLOCK && !mch_en) |=> !irq);

    // R9
    held_once_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_FSYNC && fsync_det && fs_q) |=> !irq);
endmodule

// File: rtl/rx_irq_select.sv
module rx_irq_select
    import rx_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] irq_mode,
    input  logic              mch_en,
    input  logic              rx_reset,
    input  logic              buf_load,
    input  logic              shift_full,
    input  logic              dreg_rd,
    input  logic              blk_done,
    input  logic              fsync_det,
    input  logic              fsync_unexp,
    input  logic              err_wr0,
    output logic              irq,
    output logic              rdy_flag,
    output logic              full_flag,
    output logic              err_flag
);
    logic     rdy_rise, err_rise;
    irq_src_e src;

    assign src = irq_src_e'(irq_mode);

    rx_word_flags u_words (
        .clk(clk), .rst(rst), .rx_reset(rx_reset),
        .buf_load(buf_load), .shift_full(shift_full), .dreg_rd(dreg_rd),
        .rdy(rdy_flag), .full(full_flag), .rdy_rise(rdy_rise)
    );

    rx_err_flag u_err (
        .clk(clk), .rst(rst), .rx_reset(rx_reset),
        .fsync_unexp(fsync_unexp), .err_wr0(err_wr0),
        .err(err_flag), .err_rise(err_rise)
    );

    rx_irq_mux u_mux (
        .clk(clk), .rst(rst), .src(src), .mch_en(mch_en),
        .rx_reset(rx_reset), .blk_done(blk_done), .fsync_det(fsync_det),
        .rdy_rise(rdy_rise), .err_rise(err_rise), .irq(irq)
    );

    // R1
    ready_irq_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(rdy_flag) && $past(irq_mode) == 2'd0) |-> irq);

    // R4
    err_irq_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(err_flag) && $past(irq_mode) == 2'd3) |-> irq);
endmodule

// File: tb/sim_rx_irq_select.sv
module sim_rx_irq_select;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] irq_mode = 2'd0;
    logic mch_en = 0, rx_reset = 0, buf_load = 0, shift_full = 0, dreg_rd = 0;
    logic blk_done = 0, fsync_det = 0, fsync_unexp = 0, err_wr0 = 0;
    logic irq, rdy_flag, full_flag, err_flag;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    rx_irq_select u0 (
        .clk(clk), .rst(rst), .irq_mode(irq_mode), .mch_en(mch_en),
        .rx_reset(rx_reset), .buf_load(buf_load), .shift_full(shift_full),
        .dreg_rd(dreg_rd), .blk_done(blk_done), .fsync_det(fsync_det),
        .fsync_unexp(fsync_unexp), .err_wr0(err_wr0), .irq(irq),
        .rdy_flag(rdy_flag), .full_flag(full_flag), .err_flag(err_flag)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(); tick();
        for (int m = 0; m < 4; m++) begin
            for (int mc = 0; mc < 2; mc++) begin
                for (int rr = 0; rr < 2; rr++) begin
                    logic live;
                    live = (rr == 0);
                    rst = 1'b1; tick(); tick();
                    // R9 reset state
                    chk("R9", "rst irq", irq, 1'b0);
                    chk("R9", "rst rdy", rdy_flag, 1'b0);
                    chk("R9", "rst full", full_flag, 1'b0);
                    chk("R9", "rst err", err_flag, 1'b0);
                    rst = 1'b0;
                    irq_mode = 2'(m); mch_en = mc[0]; rx_reset = rr[0];
                    tick();

                    // R1 word load, ready rises two edges later
                    buf_load = 1'b1; tick(); buf_load = 1'b0;
                    chk("R1", "rdy after load", rdy_flag, 1'b0);
                    chk("R1", "irq after load", irq, 1'b0);
                    tick();
                    chk("R1", "rdy set", rdy_flag, live);
                    chk("R1", "ready irq", irq, live && m == 0);
                    tick();
                    chk("R9", "ready irq single", irq, 1'b0);
                    chk("R1", "rdy held", rdy_flag, live);

                    // R6 receiver full, R7 read and refill
                    buf_load = 1'b1; shift_full = 1'b1; tick(); buf_load = 1'b0;
                    chk("R6", "full not yet", full_flag, 1'b0);
                    tick(); shift_full = 1'b0;
                    chk("R6", "full set", full_flag, live);
                    chk("R6", "no irq on full", irq, 1'b0);
                    dreg_rd = 1'b1; tick(); dreg_rd = 1'b0;
                    chk("R7", "rdy cleared by read", rdy_flag, 1'b0);
                    chk("R6", "full cleared by read", full_flag, 1'b0);
                    tick();
                    chk("R7", "rdy refilled", rdy_flag, live);
                    chk("R1", "refill irq", irq, live && m == 0);
                    tick();
                    chk("R7", "rdy stays", rdy_flag, live);

                    // R2 block end
                    blk_done = 1'b1; tick(); blk_done = 1'b0;
                    chk("R2", "block irq", irq, live && m == 1 && mc == 1);
                    tick();
                    chk("R2", "block irq single", irq, 1'b0);

                    // R3 frame sync held for three cycles
                    fsync_det = 1'b1; tick();
                    chk("R3", "fsync irq", irq, m == 2);
                    tick();
                    chk("R9", "fsync held no repeat", irq, 1'b0);
                    tick(); fsync_det = 1'b0;
                    chk("R9", "fsync held no repeat 2", irq, 1'b0);
                    tick();

                    // R4 / R5 sync error
                    fsync_unexp = 1'b1; tick(); fsync_unexp = 1'b0;
                    chk("R5", "err set", err_flag, live);
                    chk("R4", "err irq", irq, live && m == 3);
                    tick(); tick();
                    chk("R5", "err sticky", err_flag, live);
                    chk("R4", "err irq single", irq, 1'b0);
                    err_wr0 = 1'b1; tick(); err_wr0 = 1'b0;
                    chk("R5", "err cleared", err_flag, 1'b0);
                    fsync_unexp = 1'b1; err_wr0 = 1'b1; tick();
                    fsync_unexp = 1'b0; err_wr0 = 1'b0;
                    chk("R5", "set beats clear", err_flag, live);

                    // R8 receiver reset clears everything
                    if (live) begin
                        rx_reset = 1'b1; tick();
                        chk("R8", "rdy reset", rdy_flag, 1'b0);
                        chk("R8", "err reset", err_flag, 1'b0);
                        chk("R8", "full reset", full_flag, 1'b0);
                        chk("R8", "irq in reset", irq, 1'b0);
                        fsync_det = 1'b1; tick(); fsync_det = 1'b0;
                        chk("R3", "fsync irq in reset", irq, m == 2);
                        rx_reset = 1'b0; tick();
                    end
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule